// File: doc/BRIEF.md
# Collatz Step Counter

This block counts how many steps the 3n+1 iteration needs to bring a positive integer down to 1. A caller places a starting value on the input bus and pulses start while the core is not busy. From then on the core applies one transformation per clock. An even value is halved. An odd value becomes three times itself plus one. Each transformation adds one to a step counter. When the working value reaches 1, the core stops and raises done, and the step count is then valid.

The working register is wider than the input. If a 3n+1 result would not fit in it, the core stops and reports an overflow error. A zero input would loop forever, so the core rejects it at once with its own error flag. The results stay on the outputs until the caller issues the next accepted start.

Top module: `collatz_core`

## Requirements
- R1: While reset is high and in the first cycle after it, busy_o, done_o, err_zero_o and err_ovf_o are 0 and count_o is 0.
- R2: During a run, an even working value n is replaced by n/2 and the step count rises by one.
- R3: During a run, an odd working value n is replaced by 3n+1 and the step count rises by one.
- R4: The run ends in the cycle in which the working value becomes 1. busy_o falls and done_o rises with the final count. A start value of 1 gives done_o one cycle after the start with a count of 0.
- R5: A start value of 0 sets done_o and err_zero_o one cycle after the start, with a count of 0 and busy_o low.
- R6: If 3n+1 does not fit in WORK_W bits, the run ends with done_o and err_ovf_o set. The count keeps the number of steps already completed.
- R7: A start pulse while busy_o is high is ignored. The running computation and its final result are unchanged.
- R8: Once done_o is high, done_o, count_o and both error flags hold until the next start. That start clears them.
- R9: The step count saturates at 2^CNT_W-1 and does not wrap.
- R10: One transformation completes per clock. A start accepted at edge e with a value needing k steps shows done_o right after edge e+k, provided no overflow and no saturation occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only while not busy |
| value_i | input | IN_W | Starting value, sampled with an accepted start |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | High once a result is available, until the next start |
| count_o | output | CNT_W | Step count (saturating) |
| err_zero_o | output | 1 | The start value was zero |
| err_ovf_o | output | 1 | A 3n+1 step exceeded the working width |

## Verification
On every cycle, the assertions check the following:
- busy and done are never high together.
- A running core either steps its counter by exactly one or ends with overflow.
- A saturated count stays at its maximum.
- The results hold while done is high and no start arrives.
- Starts with values 0 and 1 finish one cycle later with the right flags.

The actual step counts need the bench's reference model and its scenarios:
- Counts for particular values, such as 3, 7 and 27.
- A start that is ignored mid-run.
- The exact cycle at which a run ends.
- An overflow triggered by a chosen input under a narrow working width.

// File: rtl/collatz_pkg.sv
package collatz_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_t;

    typedef struct packed {
        logic odd;
        logic ovf;
        logic hits_one;
    } step_flags_t;

    typedef struct packed {
        logic is_zero;
        logic is_one;
    } seed_class_t;

endpackage

// File: rtl/collatz_step.sv
module collatz_step
    import collatz_pkg::*;
#(
    parameter int W = 48
) (
    input  logic [W-1:0] n_i,
    output logic [W-1:0] nxt_o,
    output step_flags_t  flags_o
);
    localparam int TW = W + 2;

    logic [TW-1:0] triple;
    logic [W-1:0]  half;

    always_comb begin
        // 3n+1 formed as 2n + n + 1 with two guard bits
        triple = {2'b00, n_i} + {1'b0, n_i, 1'b0} + TW'(1);
        half   = n_i >> 1;
        flags_o.odd      = n_i[0];
        flags_o.ovf      = n_i[0] && (|triple[TW-1:W]);
        nxt_o            = n_i[0] ? triple[W-1:0] : half;
        flags_o.hits_one = (nxt_o == W'(1));
    end

endmodule

// File: rtl/collatz_counter.sv
module collatz_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_o,
    output logic         at_max_o
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    assign at_max_o = (cnt_q == CMAX);
    assign cnt_o    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc && !at_max_o)
            cnt_q <= cnt_q + W'(1);
    end

    // R9: never wraps while incrementing
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/collatz_core.sv
module collatz_core
    import collatz_pkg::*;
#(
    parameter int IN_W   = 32,
    parameter int WORK_W = 48,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [IN_W-1:0]   value_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              err_zero_o,
    output logic              err_ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    run_state_t        state_q;
    logic [WORK_W-1:0] n_q;
    logic [WORK_W-1:0] n_nxt;
    step_flags_t       flags;
    seed_class_t       seed;
    logic              err_zero_q, err_ovf_q;
    logic              accept, step_en, cnt_at_max;

    collatz_step #(.W(WORK_W)) u_step (
        .n_i    (n_q),
        .nxt_o  (n_nxt),
        .flags_o(flags)
    );

    always_comb begin
        seed.is_zero = (value_i == '0);
        seed.is_one  = (value_i == IN_W'(1));
        accept  = start_i && (state_q != ST_RUN);
        step_en = (state_q == ST_RUN) && !flags.ovf;
    end

    collatz_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .inc     (step_en),
        .cnt_o   (count_o),
        .at_max_o(cnt_at_max)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            n_q        <= '0;
            err_zero_q <= 1'b0;
            err_ovf_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        n_q        <= WORK_W'(value_i);
                        err_zero_q <= seed.is_zero;
                        err_ovf_q  <= 1'b0;
                        state_q    <= (seed.is_zero || seed.is_one) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (flags.ovf) begin
                        err_ovf_q <= 1'b1;
                        state_q   <= ST_DONE;
                    end else begin
                        n_q <= n_nxt;
                        if (flags.hits_one)
                            state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o     = (state_q == ST_RUN);
    assign done_o     = (state_q == ST_DONE);
    assign err_zero_o = err_zero_q;
    assign err_ovf_o  = err_ovf_q;

    // R4: busy and done exclusive
    a_r4_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));
    // R4: a seed of 1 finishes with zero steps
    a_r4_seed_one: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && value_i == IN_W'(1)) |=>
        (done_o && count_o == '0 && !err_zero_o && !err_ovf_o));
    // R5: zero seed rejected at once
    a_r5_zero: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && value_i == '0) |=>
        (done_o && err_zero_o && !busy_o && count_o == '0));
    // R6: overflow flag only with done
    a_r6_ovf_done: assert property (@(posedge clk) disable iff (rst)
        err_ovf_o |-> done_o);
    // R8: results hold while done and idle input
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=>
        (done_o && $stable(count_o) && $stable(err_zero_o) && $stable(err_ovf_o)));
    // R9: saturated count stays put
    a_r9_sat: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_at_max) |=> (count_o == CNT_MAX));
    // R10: one step per running cycle
    a_r10_one_step: assert property (@(posedge clk) disable iff (rst)
        (busy_o && count_o != CNT_MAX) |=>
        (err_ovf_o || count_o == $past(count_o) + CNT_W'(1)));
    // R7: a run ends only in done
    a_r7_run_ends_done: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

endmodule

// File: tb/sim_collatz_core.sv
module sim_collatz_core;
    localparam int IN_W = 16, WORK_W = 18, CNT_W = 6;
    localparam longint WMAX = (64'd1 << WORK_W) - 1;
    localparam int CMAX = (1 << CNT_W) - 1;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [IN_W-1:0] value = '0;
    logic busy, done, ez, eo;
    logic [CNT_W-1:0] count;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    collatz_core #(.IN_W(IN_W), .WORK_W(WORK_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .value_i(value),
        .busy_o(busy), .done_o(done), .count_o(count),
        .err_zero_o(ez), .err_ovf_o(eo)
    );

    // behavioural reference model
    bit m_busy, m_done, m_ez, m_eo;
    int m_cnt;
    longint m_n;
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_ez = 0; m_eo = 0; m_cnt = 0; m_n = 0;
        end else if (!m_busy && start) begin
            m_cnt = 0; m_ez = 0; m_eo = 0;
            if (value == 0) begin m_done = 1; m_ez = 1; end
            else if (value == 1) m_done = 1;
            else begin m_busy = 1; m_done = 0; m_n = longint'(value); end
        end else if (m_busy) begin
            longint t;
            t = (m_n % 2 == 1) ? 3 * m_n + 1 : m_n / 2;
            if (t > WMAX) begin
                m_busy = 0; m_done = 1; m_eo = 1;
            end else begin
                m_n = t;
                if (m_cnt < CMAX) m_cnt = m_cnt + 1;
                if (m_n == 1) begin m_busy = 0; m_done = 1; end
            end
        end
    end

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) if (!rst && !finished) begin
        chk("R10 busy cycle", busy, m_busy);
        chk("R10 done cycle", done, m_done);
        chk("R2 R3 count", count, m_cnt);
        chk("R5 err_zero", ez, m_ez);
        chk("R6 err_ovf", eo, m_eo);
    end

    task automatic launch(input int v);
        @(negedge clk); start = 1'b1; value = IN_W'(v);
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 done in reset", done, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 count after reset", count, 0);
        chk("R1 flags after reset", {ez, eo}, 0);

        launch(1);
        chk("R4 seed one done", done, 1);
        chk("R4 seed one count", count, 0);

        launch(0);
        chk("R5 zero done", done, 1);
        chk("R5 zero flag", ez, 1);
        chk("R5 zero busy", busy, 0);

        launch(2);
        chk("R10 busy after start", busy, 1);
        chk("R8 start clears err_zero", ez, 0);
        @(negedge clk);
        chk("R2 halving done", done, 1);
        chk("R2 halving count", count, 1);

        launch(3);
        wait_done(cyc);
        chk("R3 odd path count", count, 7);

        launch(6);
        @(negedge clk); start = 1'b1; value = IN_W'(1);
        @(negedge clk); start = 1'b0;
        chk("R7 start ignored busy", busy, 1);
        wait_done(cyc);
        chk("R7 final count", count, 8);
        repeat (5) @(negedge clk);
        chk("R8 count holds", count, 8);
        chk("R8 done holds", done, 1);

        launch(7);
        wait_done(cyc);
        chk("R10 latency", cyc, 16);
        chk("R4 count for 7", count, 16);

        launch(27);
        wait_done(cyc);
        chk("R9 saturation", count, CMAX);

        launch(65535);
        wait_done(cyc);
        chk("R6 overflow flag", eo, 1);
        chk("R6 overflow count", count, 2);
        chk("R6 overflow done", done, 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule